// File: doc/BRIEF.md
# Two-Operand ALU with Condition Flags

This block is the arithmetic and logic stage for the two-operand instruction class of a small 16-bit processor core. It takes a 4-bit operation code, a source and a destination operand, the current carry flag and a byte/word select. In the same cycle it returns the result, a write-enable that says whether the result goes back to the destination, and new values for the negative, zero, carry and overflow flags. Each flag has its own update mask, so the status register keeps its old value wherever the mask is low.

The block is purely combinational. Operand fetch, the register file and the status bits that do not hold arithmetic state are handled elsewhere. Subtraction adds the destination to the bit-inverted source, with a carry-in of one or of the incoming carry. A carry-out of one therefore means no borrow. Decimal addition works on packed BCD digits and corrects each digit on its own. Compare and bit test update flags but never write.

Top module: `twoop_alu`

## Requirements
- R1: The opcode encoding is move=4, add=5, add-with-carry=6, subtract-with-carry=7, subtract=8, compare=9, decimal-add=A, bit-test=B, bit-clear=C, bit-set=D, exclusive-or=E and and=F. All outputs are a function of the present inputs only. Flag and mask bits are ordered N, Z, C, V.
- R2: Move returns the source with write-enable 1 and all four update masks 0.
- R3: Add returns src+dst and add-with-carry returns src+dst+carry_i. Both update all four flags: C is the carry out of the operand's top bit, and V is set when both operands have the same sign and the result's sign differs.
- R4: Subtract returns dst+~src+1 and subtract-with-carry returns dst+~src+carry_i. All four flags are updated, with C and V taken from that addition.
- R5: Compare produces the same result value and flags as subtract, with write-enable 0.
- R6: Decimal-add adds src, dst and carry_i one 4-bit digit at a time. A digit sum above 9 has 6 added and carries into the next digit. C is the carry out of the top digit. N, Z and C are updated and V is left unchanged.
- R7: And returns src AND dst with write-enable 1. Bit-test returns the same value with write-enable 0. Both update all flags, with C = NOT Z and V = 0.
- R8: Exclusive-or returns src XOR dst, updates all flags, and sets C = NOT Z and V = 1 exactly when both operands are negative.
- R9: Bit-clear returns (NOT src) AND dst and bit-set returns src OR dst. Both have write-enable 1 and all update masks 0.
- R10: When byte_i is 1, only bits 7:0 of the operands are used. The result's bits 15:8 are 0, and C, V, N and Z are taken at bit 7 and over the low byte.
- R11: Whenever N is updated it equals the result's top bit (bit 7 or 15). Whenever Z is updated it is 1 exactly when the result is zero.
- R12: Opcodes 0 to 3 give result 0, write-enable 0 and all update masks 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| carry_i | input | 1 | Current carry flag |
| byte_i | input | 1 | 1 = byte operation, 0 = word |
| res_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Result is written to the destination |
| flag_n_o | output | 1 | Next negative flag |
| flag_z_o | output | 1 | Next zero flag |
| flag_c_o | output | 1 | Next carry flag |
| flag_v_o | output | 1 | Next overflow flag |
| upd_n_o | output | 1 | N update mask |
| upd_z_o | output | 1 | Z update mask |
| upd_c_o | output | 1 | C update mask |
| upd_v_o | output | 1 | V update mask |

## Verification
The assertions check a set of invariants for every input combination the bench applies:
- the upper byte is clear in byte mode;
- compare and bit-test never write;
- an updated N or Z agrees with the result;
- decimal digits stay in range when the inputs are valid BCD;
- the logical operations keep C equal to NOT Z.

Actual arithmetic values cannot be shown by any invariant. These include the carry and overflow on sign boundaries, the borrow convention of subtract-with-carry, and decimal carries running through several digits. The bench shows them with hand-worked vectors and a sweep against an independent reference model.

// File: rtl/twoop_alu_pkg.sv
package twoop_alu_pkg;
  localparam logic [3:0] OP_MOV  = 4'h4;
  localparam logic [3:0] OP_ADD  = 4'h5;
  localparam logic [3:0] OP_ADDC = 4'h6;
  localparam logic [3:0] OP_SUBC = 4'h7;
  localparam logic [3:0] OP_SUB  = 4'h8;
  localparam logic [3:0] OP_CMP  = 4'h9;
  localparam logic [3:0] OP_DADD = 4'hA;
  localparam logic [3:0] OP_BIT  = 4'hB;
  localparam logic [3:0] OP_BIC  = 4'hC;
  localparam logic [3:0] OP_BIS  = 4'hD;
  localparam logic [3:0] OP_XOR  = 4'hE;
  localparam logic [3:0] OP_AND  = 4'hF;
endpackage

// File: rtl/twoop_alu_add.sv
module twoop_alu_add #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] full_sum;
  logic [HALF_W:0] low_sum;

  assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign low_sum  = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]}
                  + {{HALF_W{1'b0}}, cin_i};

  always_comb begin
    if (byte_i) begin
      sum_o  = {{(DATA_W-HALF_W){1'b0}}, low_sum[HALF_W-1:0]};
      cout_o = low_sum[HALF_W];
      ovf_o  = (a_i[HALF_W-1] == b_i[HALF_W-1]) && (low_sum[HALF_W-1] != a_i[HALF_W-1]);
    end else begin
      sum_o  = full_sum[DATA_W-1:0];
      cout_o = full_sum[DATA_W];
      ovf_o  = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (full_sum[DATA_W-1] != a_i[DATA_W-1]);
    end
  end
endmodule

// File: rtl/twoop_alu_bcd.sv
module twoop_alu_bcd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int DIGITS   = DATA_W / 4;
  localparam int LO_DIGIT = DIGITS / 2;

  logic [DIGITS:0]   dcarry;
  logic [DATA_W-1:0] raw_sum;

  assign dcarry[0] = cin_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    logic [4:0] dsum;
    assign dsum = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]} + {4'b0000, dcarry[k]};
    assign dcarry[k+1]     = (dsum > 5'd9);
    assign raw_sum[4*k +: 4] = (dsum > 5'd9) ? (dsum[3:0] + 4'd6) : dsum[3:0];
  end

  assign sum_o  = byte_i ? {{(DATA_W-4*LO_DIGIT){1'b0}}, raw_sum[4*LO_DIGIT-1:0]} : raw_sum;
  assign cout_o = byte_i ? dcarry[LO_DIGIT] : dcarry[DIGITS];

  always_comb begin
    for (int k = 0; k < DIGITS; k++) begin
      if (a_i[4*k +: 4] <= 4'd9 && b_i[4*k +: 4] <= 4'd9) begin
        // R6
        bcd_digit_chk: assert (raw_sum[4*k +: 4] <= 4'd9)
          else $error("decimal digit %0d out of range", k);
      end
    end
  end
endmodule

// File: rtl/twoop_alu_logic.sv
module twoop_alu_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] mov_o,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] bic_o,
  output logic [DATA_W-1:0] bis_o,
  output logic [DATA_W-1:0] xor_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] keep;

  assign keep  = byte_i ? {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
  assign mov_o = src_i & keep;
  assign and_o = src_i & dst_i & keep;
  assign bic_o = ~src_i & dst_i & keep;
  assign bis_o = (src_i | dst_i) & keep;
  assign xor_o = (src_i ^ dst_i) & keep;
endmodule

// File: rtl/twoop_alu.sv
module twoop_alu
  import twoop_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              carry_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_en_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              upd_n_o,
  output logic              upd_z_o,
  output logic              upd_c_o,
  output logic              upd_v_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] add_b, add_sum, bcd_sum;
  logic              add_cin, add_cout, add_ovf, bcd_cout;
  logic [DATA_W-1:0] lg_mov, lg_and, lg_bic, lg_bis, lg_xor;
  logic              src_neg, dst_neg, c_from_z, res_msb, res_zero;

  always_comb begin
    add_b   = src_i;
    add_cin = 1'b0;
    case (op_i)
      OP_ADDC:        add_cin = carry_i;
      OP_SUB, OP_CMP: begin add_b = ~src_i; add_cin = 1'b1;    end
      OP_SUBC:        begin add_b = ~src_i; add_cin = carry_i; end
      default: ;
    endcase
  end

  twoop_alu_add #(.DATA_W(DATA_W)) u_add (
    .a_i(dst_i), .b_i(add_b), .cin_i(add_cin), .byte_i(byte_i),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  twoop_alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .a_i(src_i), .b_i(dst_i), .cin_i(carry_i), .byte_i(byte_i),
    .sum_o(bcd_sum), .cout_o(bcd_cout)
  );

  twoop_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .src_i(src_i), .dst_i(dst_i), .byte_i(byte_i),
    .mov_o(lg_mov), .and_o(lg_and), .bic_o(lg_bic), .bis_o(lg_bis), .xor_o(lg_xor)
  );

  assign src_neg = byte_i ? src_i[HALF_W-1] : src_i[DATA_W-1];
  assign dst_neg = byte_i ? dst_i[HALF_W-1] : dst_i[DATA_W-1];

  always_comb begin
    res_o    = '0;
    wr_en_o  = 1'b0;
    flag_c_o = 1'b0;
    flag_v_o = 1'b0;
    upd_n_o  = 1'b0;
    upd_z_o  = 1'b0;
    upd_c_o  = 1'b0;
    upd_v_o  = 1'b0;
    c_from_z = 1'b0;
    case (op_i)
      OP_MOV: begin res_o = lg_mov; wr_en_o = 1'b1; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res_o    = add_sum;
        wr_en_o  = (op_i != OP_CMP);
        flag_c_o = add_cout;
        flag_v_o = add_ovf;
        {upd_n_o, upd_z_o, upd_c_o, upd_v_o} = 4'b1111;
      end
      OP_DADD: begin
        res_o    = bcd_sum;
        wr_en_o  = 1'b1;
        flag_c_o = bcd_cout;
        {upd_n_o, upd_z_o, upd_c_o} = 3'b111;
      end
      OP_AND, OP_BIT: begin
        res_o    = lg_and;
        wr_en_o  = (op_i == OP_AND);
        c_from_z = 1'b1;
        {upd_n_o, upd_z_o, upd_c_o, upd_v_o} = 4'b1111;
      end
      OP_XOR: begin
        res_o    = lg_xor;
        wr_en_o  = 1'b1;
        c_from_z = 1'b1;
        flag_v_o = src_neg & dst_neg;
        {upd_n_o, upd_z_o, upd_c_o, upd_v_o} = 4'b1111;
      end
      OP_BIC: begin res_o = lg_bic; wr_en_o = 1'b1; end
      OP_BIS: begin res_o = lg_bis; wr_en_o = 1'b1; end
      default: ;
    endcase
    res_msb  = byte_i ? res_o[HALF_W-1] : res_o[DATA_W-1];
    res_zero = byte_i ? (res_o[HALF_W-1:0] == '0) : (res_o == '0);
    flag_n_o = res_msb;
    flag_z_o = res_zero;
    if (c_from_z) flag_c_o = ~res_zero;
  end

  always_comb begin
    if (byte_i) begin
      // R10
      byte_clear_chk: assert (res_o[DATA_W-1:HALF_W] == '0)
        else $error("upper byte not cleared");
    end
    if (op_i == OP_CMP || op_i == OP_BIT) begin
      // R5
      no_write_chk: assert (!wr_en_o) else $error("flag-only op writes");
    end
    if (op_i < OP_MOV) begin
      // R12
      unused_op_chk: assert (!wr_en_o && !upd_n_o && !upd_z_o && !upd_c_o && !upd_v_o)
        else $error("unused opcode has effect");
    end
    if (upd_z_o) begin
      // R11
      zero_flag_chk: assert (flag_z_o == (res_o == '0)) else $error("Z mismatch");
    end
    if (upd_n_o) begin
      // R11
      neg_flag_chk: assert (flag_n_o == (byte_i ? res_o[HALF_W-1] : res_o[DATA_W-1]))
        else $error("N mismatch");
    end
    if (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR) begin
      // R7
      logic_carry_chk: assert (flag_c_o != flag_z_o) else $error("logic C not NOT Z");
    end
  end
endmodule

// File: tb/twoop_alu_bench.sv
module twoop_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  op;
  logic [15:0] src, dst;
  logic        cin, byt;
  logic [15:0] res;
  logic        wr, fn, fz, fc, fv, un, uz, uc, uv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  twoop_alu u_twoop_alu (
    .op_i(op), .src_i(src), .dst_i(dst), .carry_i(cin), .byte_i(byt),
    .res_o(res), .wr_en_o(wr),
    .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv),
    .upd_n_o(un), .upd_z_o(uz), .upd_c_o(uc), .upd_v_o(uv)
  );

  // vector: op, byte, cin, src, dst, res, wr, flags NZCV, mask NZCV
  localparam int NV = 22;
  localparam logic [62:0] VECS [NV] = '{
    {4'h4, 1'b0, 1'b0, 16'h1234, 16'hFFFF, 16'h1234, 1'b1, 4'b0000, 4'b0000}, // R2
    {4'h5, 1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 4'b1001, 4'b1111}, // R3
    {4'h5, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b0110, 4'b1111}, // R3
    {4'h6, 1'b0, 1'b1, 16'h0001, 16'h0001, 16'h0003, 1'b1, 4'b0000, 4'b1111}, // R3
    {4'h8, 1'b0, 1'b0, 16'h0001, 16'h0001, 16'h0000, 1'b1, 4'b0110, 4'b1111}, // R4
    {4'h8, 1'b0, 1'b0, 16'h0002, 16'h0001, 16'hFFFF, 1'b1, 4'b1000, 4'b1111}, // R4
    {4'h7, 1'b0, 1'b0, 16'h0001, 16'h0005, 16'h0003, 1'b1, 4'b0010, 4'b1111}, // R4
    {4'h9, 1'b0, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b0, 4'b0011, 4'b1111}, // R5
    {4'hA, 1'b0, 1'b0, 16'h0019, 16'h0028, 16'h0047, 1'b1, 4'b0000, 4'b1110}, // R6
    {4'hA, 1'b0, 1'b1, 16'h9999, 16'h0000, 16'h0000, 1'b1, 4'b0110, 4'b1110}, // R6
    {4'hB, 1'b0, 1'b0, 16'h00F0, 16'h0F0F, 16'h0000, 1'b0, 4'b0100, 4'b1111}, // R7
    {4'hC, 1'b0, 1'b0, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 4'b0000, 4'b0000}, // R9
    {4'hD, 1'b0, 1'b0, 16'h000F, 16'h1230, 16'h123F, 1'b1, 4'b0000, 4'b0000}, // R9
    {4'hE, 1'b0, 1'b0, 16'h8000, 16'h8001, 16'h0001, 1'b1, 4'b0011, 4'b1111}, // R8
    {4'hF, 1'b0, 1'b0, 16'hFF00, 16'h8F0F, 16'h8F00, 1'b1, 4'b1010, 4'b1111}, // R7
    {4'h5, 1'b1, 1'b0, 16'h00FF, 16'hAB01, 16'h0000, 1'b1, 4'b0110, 4'b1111}, // R10
    {4'h5, 1'b1, 1'b0, 16'h0070, 16'h0010, 16'h0080, 1'b1, 4'b1001, 4'b1111}, // R10
    {4'h4, 1'b1, 1'b0, 16'hABCD, 16'h0000, 16'h00CD, 1'b1, 4'b0000, 4'b0000}, // R10
    {4'hA, 1'b1, 1'b0, 16'h0055, 16'h0055, 16'h0010, 1'b1, 4'b0010, 4'b1110}, // R10
    {4'h8, 1'b1, 1'b0, 16'h0001, 16'hFF00, 16'h00FF, 1'b1, 4'b1000, 4'b1111}, // R10
    {4'h3, 1'b0, 1'b1, 16'h1111, 16'h2222, 16'h0000, 1'b0, 4'b0000, 4'b0000}, // R12
    {4'hE, 1'b1, 1'b0, 16'h0080, 16'h0080, 16'h0000, 1'b1, 4'b0101, 4'b1111}  // R8
  };

  function automatic string req_of(input logic [3:0] o, input logic b);
    if (b) return "R10";
    case (o)
      4'h4: return "R2";
      4'h5, 4'h6: return "R3";
      4'h7, 4'h8: return "R4";
      4'h9: return "R5";
      4'hA: return "R6";
      4'hB, 4'hF: return "R7";
      4'hE: return "R8";
      4'hC, 4'hD: return "R9";
      default: return "R12";
    endcase
  endfunction

  // reference: {res, wr, flags NZCV, mask NZCV}
  function automatic logic [24:0] ref_model(input logic [3:0] o, input logic [15:0] s,
                                            input logic [15:0] d, input logic ci, input logic b);
    int w = b ? 8 : 16;
    int lim = 1 << w;
    int sv = b ? int'(s[7:0]) : int'(s);
    int dv = b ? int'(d[7:0]) : int'(d);
    int t = 0;
    int r = 0;
    logic wr_e = 1'b0, c = 1'b0, v = 1'b0, n, z;
    logic [3:0] m = 4'b0000;
    bit sn = s[w-1], dn = d[w-1];
    case (o)
      4'h4: begin r = sv; wr_e = 1; end
      4'h5, 4'h6, 4'h7, 4'h8, 4'h9: begin
        int bv = (o >= 4'h7) ? (lim - 1 - sv) : sv;
        int cv = (o == 4'h5) ? 0 : (o == 4'h6 || o == 4'h7) ? int'(ci) : 1;
        bit bn = (o >= 4'h7) ? !sn : sn;
        t = dv + bv + cv;
        r = t % lim;
        c = (t >= lim);
        v = (dn == bn) && (((r >> (w-1)) & 1) != int'(dn));
        wr_e = (o != 4'h9);
        m = 4'b1111;
      end
      4'hA: begin
        int cy = int'(ci);
        for (int k = 0; k < w/4; k++) begin
          int ds = ((sv >> (4*k)) & 15) + ((dv >> (4*k)) & 15) + cy;
          if (ds > 9) begin ds = (ds + 6) & 15; cy = 1; end else cy = 0;
          r = r | (ds << (4*k));
        end
        c = cy; wr_e = 1; m = 4'b1110;
      end
      4'hB, 4'hF: begin r = sv & dv; wr_e = (o == 4'hF); c = (r != 0); m = 4'b1111; end
      4'hE: begin r = sv ^ dv; wr_e = 1; c = (r != 0); v = sn & dn; m = 4'b1111; end
      4'hC: begin r = (~sv) & dv & (lim - 1); wr_e = 1; end
      4'hD: begin r = sv | dv; wr_e = 1; end
      default: ;
    endcase
    n = ((r >> (w-1)) & 1) != 0;
    z = (r == 0);
    return {r[15:0], wr_e, n, z, c, v, m};
  endfunction

  task automatic compare(input string tag, input logic [24:0] e);
    logic [3:0] gm = {un, uz, uc, uv};
    logic [3:0] gf = {fn, fz, fc, fv};
    checks++;
    if (res !== e[24:9] || wr !== e[8] || gm !== e[3:0] || (gf & e[3:0]) !== (e[7:4] & e[3:0])) begin
      fails++;
      $display("FAIL %s op=%h byte=%0d: got res=%h wr=%0d flg=%b msk=%b exp res=%h wr=%0d flg=%b msk=%b",
               tag, op, byt, res, wr, gf, gm, e[24:9], e[8], e[7:4], e[3:0]);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [15:0] s, input logic [15:0] d,
                       input logic ci, input logic b);
    @(negedge clk);
    op = o; src = s; dst = d; cin = ci; byt = b;
    #1;
  endtask

  initial begin
    op = 4'h0; src = '0; dst = '0; cin = 1'b0; byt = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 R12: idle state after reset, unused opcode 0 has no effect
    drive(4'h0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    compare("R12", {16'h0000, 1'b0, 4'b0000, 4'b0000});
    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][62:59], VECS[i][56:41], VECS[i][40:25], VECS[i][57], VECS[i][58]);
      compare(req_of(VECS[i][62:59], VECS[i][58]), VECS[i][24:0]);
    end
    // R4 borrow chain: subtract-with-carry with carry 1 equals plain subtract
    drive(4'h7, 16'h1234, 16'h1000, 1'b1, 1'b0);
    compare("R4", {16'hFDCC, 1'b1, 4'b1000, 4'b1111});
    // R6 decimal carry ripples through every digit of a word
    drive(4'hA, 16'h0001, 16'h9999, 1'b0, 1'b0);
    compare("R6", {16'h0000, 1'b1, 4'b0110, 4'b1110});
    // R11 sweep of all opcodes and widths against the reference model
    begin
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int i = 0; i < 320; i++) begin
        logic [3:0] o = i[3:0];
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        drive(o, lf[15:0], lf[31:16], lf[3], i[4]);
        compare((i[4] ? "R10" : "R11"), ref_model(o, lf[15:0], lf[31:16], lf[3], i[4]));
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule